// File: doc/BRIEF.md
# Word-Addressed Synchronous Memory Bus Target

This block puts an on-chip memory with a registered read port behind a simple peripheral bus window. A bus master presents an enable, a write flag, a local byte address and a 32-bit write word. The block returns a read word and a wait flag. Every access moves one whole 32-bit word. There are no byte or halfword transfers and no lane selects.

The memory's clock enable is the bus enable itself. A write is stored at the clock edge that closes its only cycle, so it never stalls. A read needs the registered memory output, so it takes two cycles. In the first cycle the wait flag is raised. In the second cycle the wait flag is low and the word is returned. The enable is still high in the second cycle, so the memory repeats the fetch of the same word at the end of that cycle. That repeated result is never presented.

A two-state controller tracks whether a read is in its first or its completing cycle. The wait flag is the only back-pressure. While wait is high, the master must hold enable, write flag and address unchanged. When wait is low in an enabled cycle, the access completes at the next rising edge.

Top module: `wram_slave`

## Requirements
- R1: Only whole words are addressed. The word index is address bits IDX_W+1 down to 2, where IDX_W = log2(DEPTH). Address bits 1 and 0 have no effect on which word is read or written.
- R2: Address bits above IDX_W+1 are ignored. Addresses that differ only in those bits reach the same word.
- R3: During an enabled write, wait_o stays low. The word is stored at the rising edge that ends that cycle, and a later read of the same index returns it.
- R4: In the first cycle of an enabled read, wait_o is high. This cycle starts with the controller idle, and wait_o follows en_i and wr_i in the same cycle.
- R5: In the second cycle of a read, wait_o is low and rdata_o equals the word stored at the addressed index.
- R6: The controller returns to idle after every completing cycle. Back-to-back reads therefore each take exactly two cycles, and wait_o is never high in two consecutive cycles.
- R7: rdata_o is zero in every cycle that is not the completing cycle of a read. This includes write cycles, idle cycles and first read cycles.
- R8: While rst_n is low and after it is released, the controller is idle, wait_o is low and rdata_o is zero.
- R9: With en_i low, nothing is stored, even if wr_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| en_i | input | 1 | Bus enable; also the memory clock enable |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Local byte address; bits IDX_W+1..2 select the word |
| wdata_i | input | DATA_W | Write word |
| rdata_o | output | DATA_W | Read word, non-zero only in the completing read cycle |
| wait_o | output | 1 | High in the first cycle of a read |

## Verification
A controller stuck in its completing state would drop the wait flag in the first read cycle. It would also return stale or zero data one cycle early, and the very next read shows this. A controller that fails to return to idle would show a missing wait on the second of two back-to-back reads. A wrong index slice shows up as aliasing mismatches within one sweep of all words, using varied low and high address bits. A write that leaks through while disabled shows up at the following read of that word.

// File: rtl/wram_pkg.sv
package wram_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DONE = 1'b1
  } rd_phase_e;
endpackage

// File: rtl/wram_index.sv
module wram_index #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int TOP = IDX_W + 2;

  assign idx_o = addr_i[TOP-1:2];

  logic [1:0] unused_low;
  assign unused_low = addr_i[1:0];

  generate
    if (ADDR_W > TOP) begin : g_upper
      logic [ADDR_W-TOP-1:0] unused_high;
      assign unused_high = addr_i[ADDR_W-1:TOP];
    end
  endgenerate
endmodule

// File: rtl/wram_wait_fsm.sv
module wram_wait_fsm
  import wram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic wr_i,
  output logic wait_o,
  output logic done_o
);
  rd_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = PH_IDLE;
    if (ph_q == PH_IDLE && en_i && !wr_i) ph_d = PH_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign wait_o = (ph_q == PH_IDLE) && en_i && !wr_i;
  assign done_o = (ph_q == PH_DONE);
endmodule

// File: rtl/wram_array.sv
module wram_array #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce_i) begin
      if (we_i) mem[idx_i] <= wdata_i;
      else      q_o        <= mem[idx_i];
    end
  end
endmodule

// File: rtl/wram_slave.sv
module wram_slave #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] mem_q;
  logic              rd_done;

  wram_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
    .addr_i (addr_i),
    .idx_o  (word_idx)
  );

  wram_wait_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .wr_i   (wr_i),
    .wait_o (wait_o),
    .done_o (rd_done)
  );

  wram_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .ce_i    (en_i),
    .we_i    (wr_i),
    .idx_i   (word_idx),
    .wdata_i (wdata_i),
    .q_o     (mem_q)
  );

  // Only the fetch taken at the end of the first read cycle is shown.
  assign rdata_o = rd_done ? mem_q : '0;
endmodule

// File: rtl/wram_slave_chk.sv
module wram_slave_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              wr_i,
  input logic              wait_o,
  input logic              rd_done,
  input logic [DATA_W-1:0] rdata_o
);
  a_r3_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wr_i) |-> !wait_o);

  a_r4_first_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wr_i && !rd_done) |-> wait_o);

  a_r5_wait_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |=> (rd_done && !wait_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  a_r6_no_double_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |=> !wait_o);

  a_r7_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> (rdata_o == '0));
endmodule

bind wram_slave wram_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .wr_i    (wr_i),
  .wait_o  (wait_o),
  .rd_done (rd_done),
  .rdata_o (rdata_o)
);

// File: tb/wram_slave_tb_top.sv
`timescale 1ns/1ps
module wram_slave_tb_top;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en_i = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              wait_o;

  int tests = 0;
  int fails = 0;
  logic [DATA_W-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  wram_slave #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wait_o(wait_o)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int idx, input int hi, input int lo);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[1:0] = lo[1:0];
    a[IDX_W+1:2] = idx[IDX_W-1:0];
    a[ADDR_W-1:IDX_W+2] = hi[ADDR_W-IDX_W-3:0];
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] pattern(input int idx, input int salt);
    return (32'h9E3779B9 * (idx + 1)) ^ (salt * 32'h01010101);
  endfunction

  // All tasks start just after a falling edge and end at a falling edge.
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    en_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    #1;
    check("R3 wait low on write", {31'b0, wait_o}, 32'd0);
    check("R7 rdata zero on write", rdata_o, '0);
    @(negedge clk);
    model[a[IDX_W+1:2]] = d;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] exp;
    exp = model[a[IDX_W+1:2]];
    en_i = 1'b1; wr_i = 1'b0; addr_i = a; wdata_i = '1;
    #1;
    check("R4 wait high in first read cycle", {31'b0, wait_o}, 32'd1);
    check("R7 rdata zero in first read cycle", rdata_o, '0);
    @(negedge clk);
    #1;
    check("R6 wait low in completing cycle", {31'b0, wait_o}, 32'd0);
    check("R5 R1 R2 read data", rdata_o, exp);
    @(negedge clk);
  endtask

  task automatic do_idle(input logic wr, input logic [DATA_W-1:0] d);
    en_i = 1'b0; wr_i = wr; wdata_i = d;
    #1;
    check("R7 rdata zero when idle", rdata_o, '0);
    check("R9 wait low when disabled", {31'b0, wait_o}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8 wait low in reset", {31'b0, wait_o}, 32'd0);
    check("R8 rdata zero in reset", rdata_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 wait low after reset", {31'b0, wait_o}, 32'd0);
    check("R8 rdata zero after reset", rdata_o, '0);

    // R1 R2: fill every word through varied low/high address bits
    for (int i = 0; i < DEPTH; i++) do_write(mk_addr(i, i * 3, i), pattern(i, 1));
    do_idle(1'b0, '0);
    // R6: back-to-back reads, each through a different alias
    for (int i = 0; i < DEPTH; i++) do_read(mk_addr(i, i + 5, 3 - (i % 4)));
    do_idle(1'b0, '0);
    // Reverse order, aliases on high bits only
    for (int i = DEPTH - 1; i >= 0; i--) do_read(mk_addr(i, 63 - i, 0));

    // R9: disabled cycles with write flag high must not store
    for (int i = 0; i < 4; i++) begin
      addr_i = mk_addr(5, 0, 0);
      do_idle(1'b1, 32'hDEAD0000 + i);
    end
    do_read(mk_addr(5, 1, 2));

    // R3: write immediately followed by read of the same word, then mixed
    for (int i = 0; i < DEPTH; i++) begin
      do_write(mk_addr(i, i, 1), pattern(i, 7));
      do_read(mk_addr(i, i + 1, 2));
    end
    do_write(mk_addr(2, 0, 0), 32'h0);
    do_read(mk_addr(2, 3, 3));
    do_write(mk_addr(15, 0, 0), 32'hFFFF_FFFF);
    do_read(mk_addr(15, 2, 1));
    do_idle(1'b0, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule